// File: doc/BRIEF.md
# Chip-Select-Triggered SAR Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation converter. It has no start pulse. A falling edge on the active-low select input, seen while the block is idle and awake, opens the hold switch and starts a conversion. The conversion runs on an internal decision tick, which is the system clock divided by a parameter, so no serial clock is needed. After one setup tick, the sequencer tests one bit per tick, starting at the most significant bit. Each trial code goes out to the capacitive DAC. The bench supplies a single-bit comparator answer that says whether that code lies above the held input. At the last decision the result register is loaded, a one-cycle done pulse is given, and the input returns to tracking.

Raising the select input before the end of the conversion abandons it. The block then waits a fixed acquisition window, during which it accepts no start, so the hold capacitor can settle again. A low level on the shutdown input stops all activity at once. A start is then refused until a wake-up interval of continuous high shutdown input has elapsed. The same interval applies after reset.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `busy`, `hold`, `done`, `dac_code` and `result` are all zero.
- R2: A conversion starts only at a clock edge where `cs_n` is low and was high at the previous edge, while the block is idle and awake. Holding `cs_n` low after a conversion does not start another one.
- R3: `hold` and `busy` are high from the clock edge that accepts a start until the conversion completes or stops. Both are low at all other times.
- R4: After a start there is one setup phase of TICK_DIV cycles, followed by WIDTH trial phases of TICK_DIV cycles each, most significant bit first. `done` is high exactly (WIDTH+1)*TICK_DIV cycles after the start edge. While bit b is on trial, `dac_code` holds the bits above b as already decided, bit b set to 1, and the lower bits at 0.
- R5: At the end of its trial phase, a bit is cleared if `cmp_above` is 1 and kept if it is 0. The final code is straight unipolar binary, so it equals the input level expressed in LSBs of reference/2^WIDTH.
- R6: `done` is a one-cycle pulse. `result` takes the final code at the same edge and keeps it until the next completed conversion. The block is idle in the cycle after `done`, and a new falling edge is accepted at once.
- R7: If `cs_n` is high at an edge during a conversion, the conversion stops. No `done` is given and `result` is unchanged. For the next ACQ_CYCLES cycles a falling edge on `cs_n` is ignored.
- R8: If `cs_n` is high at the very edge that would complete a conversion, the abort takes precedence: there is no `done`, no result load, and the acquisition window follows.
- R9: A low `shdn_n` at an edge ends any activity and leaves the block idle. No start is accepted until `shdn_n` has been high for WAKE_CYCLES consecutive edges. The same rule applies after reset.
- R10: `dac_code` is zero whenever no bit trial is in progress, including during the setup phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the decision tick is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; a falling edge starts, a high level during conversion aborts |
| shdn_n | input | 1 | Active-low shutdown |
| cmp_above | input | 1 | Comparator answer: trial code is above the held input |
| hold | output | 1 | Track/hold control, 1 = hold |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when `result` is loaded |
| dac_code | output | WIDTH | Trial code to the binary-weighted DAC |
| result | output | WIDTH | Last completed conversion result |

## Verification
The sharpest collision is between completing a conversion and aborting it, which can fall in the same cycle. The bench raises `cs_n` so that it is sampled exactly at the edge of the final bit decision. It expects no `done`, an unchanged `result`, and an acquisition window that swallows the next falling edge. The bench then repeats the run with `cs_n` raised one edge later, where it expects a normal completion. A second overlap pairs a falling select edge with an unfinished wake-up or acquisition window, and the bench judges that case by `busy` staying low. A cycle-level reference model in the bench compares every output on every clock.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    SQ_TRACK  = 3'd0,
    SQ_SAMPLE = 3'd1,
    SQ_TRIAL  = 3'd2,
    SQ_DONE   = 3'd3,
    SQ_ACQ    = 3'd4
  } sq_state_e;

endpackage

// File: rtl/sar_tick_div.sv
// Decision tick: one pulse every DIV cycles while run is high, phase
// restarted whenever run is low.
module sar_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LASTV = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                cnt_d = '0;
    else if (cnt_q == LASTV) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LASTV);
endmodule

// File: rtl/sar_win_cnt.sv
// Saturating window counter: cleared by clr, advances while en is high,
// reached is high once LIMIT advances have been made.
module sar_win_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic reached
);
  localparam int unsigned CW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] TOPV = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  assign reached = (cnt_q == TOPV);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (en && !reached) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_bit_reg.sv
// Successive-approximation register with a one-hot trial pointer.
module sar_bit_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed,
  input  logic         step,
  input  logic         cmp_above,
  output logic [W-1:0] code,
  output logic [W-1:0] settled,
  output logic         on_lsb
);
  logic [W-1:0] ptr_q, ptr_d, code_q, code_d;

  // current trial bit resolved by the comparator answer
  for (genvar i = 0; i < W; i++) begin : g_resolve
    assign settled[i] = code_q[i] & ~(ptr_q[i] & cmp_above);
  end

  always_comb begin
    ptr_d  = ptr_q;
    code_d = code_q;
    if (seed) begin
      ptr_d  = {1'b1, {(W-1){1'b0}}};
      code_d = {1'b1, {(W-1){1'b0}}};
    end else if (step) begin
      ptr_d  = ptr_q >> 1;
      code_d = settled | (ptr_q >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      code_q <= '0;
    end else if (seed || step) begin
      ptr_q  <= ptr_d;
      code_q <= code_d;
    end
  end

  assign code   = code_q;
  assign on_lsb = ptr_q[0];
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int unsigned WIDTH       = 12,
  parameter int unsigned TICK_DIV    = 4,
  parameter int unsigned ACQ_CYCLES  = 188,
  parameter int unsigned WAKE_CYCLES = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             shdn_n,
  input  logic             cmp_above,
  output logic             hold,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result
);
  import sar_seq_pkg::*;

  localparam int unsigned ACQ_LIM = (ACQ_CYCLES > 0) ? ACQ_CYCLES - 1 : 0;

  sq_state_e        st_q, st_d;
  logic             cs_q;
  logic             cs_fall;
  logic             awake;
  logic             acq_end;
  logic             tick;
  logic             converting;
  logic             seed, step, res_load;
  logic             on_lsb;
  logic [WIDTH-1:0] code, settled, result_q;

  assign cs_fall    = cs_q & ~cs_n;
  assign converting = (st_q == SQ_SAMPLE) || (st_q == SQ_TRIAL);

  sar_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(converting), .tick(tick)
  );

  sar_win_cnt #(.LIMIT(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(rst_n), .clr(!shdn_n), .en(1'b1), .reached(awake)
  );

  sar_win_cnt #(.LIMIT(ACQ_LIM)) u_acq (
    .clk(clk), .rst_n(rst_n), .clr(st_q != SQ_ACQ), .en(st_q == SQ_ACQ),
    .reached(acq_end)
  );

  sar_bit_reg #(.W(WIDTH)) u_sar (
    .clk(clk), .rst_n(rst_n), .seed(seed), .step(step),
    .cmp_above(cmp_above), .code(code), .settled(settled), .on_lsb(on_lsb)
  );

  // next state: shutdown first, then abort, then tick-driven progress
  always_comb begin
    st_d = st_q;
    if (!shdn_n) begin
      st_d = SQ_TRACK;
    end else begin
      unique case (st_q)
        SQ_TRACK:  if (cs_fall && awake) st_d = SQ_SAMPLE;
        SQ_SAMPLE: if (cs_n) st_d = SQ_ACQ;
                   else if (tick) st_d = SQ_TRIAL;
        SQ_TRIAL:  if (cs_n) st_d = SQ_ACQ;
                   else if (tick && on_lsb) st_d = SQ_DONE;
        SQ_DONE:   st_d = SQ_TRACK;
        SQ_ACQ:    if (acq_end) st_d = SQ_TRACK;
        default:   st_d = SQ_TRACK;
      endcase
    end
  end

  assign seed     = (st_q == SQ_SAMPLE) && (st_d == SQ_TRIAL);
  assign step     = (st_q == SQ_TRIAL) && tick && (st_d != SQ_ACQ) &&
                    (st_d != SQ_TRACK);
  assign res_load = (st_q == SQ_TRIAL) && (st_d == SQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_TRACK;
      cs_q <= 1'b1;
    end else begin
      st_q <= st_d;
      cs_q <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_q <= '0;
    else if (res_load) result_q <= settled;
  end

  assign hold     = converting;
  assign busy     = converting;
  assign done     = (st_q == SQ_DONE);
  assign dac_code = (st_q == SQ_TRIAL) ? code : '0;
  assign result   = result_q;
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int unsigned WIDTH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             shdn_n,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cs_n) && $past(cs_n, 2))); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R6

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_n) |=> (!busy && !done)); // R7

  AST_ABORT_BEATS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !$past(cs_n))); // R8

  AST_SHDN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (!busy && !done)); // R9
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .shdn_n(shdn_n),
  .busy(busy), .done(done), .result(result)
);

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;
  localparam int W    = 12;
  localparam int DIV  = 3;
  localparam int ACQ  = 10;
  localparam int WAKE = 16;
  localparam int CONV = (W + 1) * DIV;

  logic clk, rst_n, cs_n, shdn_n, cmp_above;
  logic hold, busy, done;
  logic [W-1:0] dac_code, result, vin;

  int n_tests = 0;
  int n_fail  = 0;
  bit run_cmp = 0;

  sar_conv_seq #(.WIDTH(W), .TICK_DIV(DIV), .ACQ_CYCLES(ACQ),
                 .WAKE_CYCLES(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .shdn_n(shdn_n),
    .cmp_above(cmp_above), .hold(hold), .busy(busy), .done(done),
    .dac_code(dac_code), .result(result)
  );

  // comparator model: trial code above the held input
  assign cmp_above = (dac_code > vin);

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 converting, 2 done, 3 acquiring
  int m_phase, m_age, m_acq, m_wake;
  bit m_csp, m_fall;
  logic [W-1:0] m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_age = 0; m_acq = 0; m_wake = 0; m_csp = 1; m_res = '0;
    end else begin
      m_fall = m_csp && !cs_n;
      if (!shdn_n) begin
        m_phase = 0; m_wake = 0;
      end else begin
        case (m_phase)
          0: if (m_fall && m_wake >= WAKE) begin m_phase = 1; m_age = 1; end
          1: if (cs_n) begin m_phase = 3; m_acq = 1; end
             else if (m_age == CONV) begin m_phase = 2; m_res = vin; end
             else m_age++;
          2: m_phase = 0;
          default: if (m_acq == ACQ) m_phase = 0; else m_acq++;
        endcase
        if (m_wake < WAKE) m_wake++;
      end
      m_csp = cs_n;
    end
  end

  function automatic logic [31:0] exp_dac();
    int t, b, v;
    if (m_phase != 1 || m_age <= DIV) return 0;  // R10
    t = (m_age - 1) / DIV - 1;
    b = W - 1 - t;
    v = int'(vin);
    return ((v >> (b + 1)) << (b + 1)) | (1 << b);
  endfunction

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk("R3 busy", busy, (m_phase == 1));
      chk("R3 hold", hold, (m_phase == 1));
      chk("R6 done", done, (m_phase == 2));
      chk("R5 result", result, m_res);
      chk("R4 dac_code", dac_code, exp_dac());
    end
  end

  task automatic convert(input logic [W-1:0] v);
    int lat;
    lat = -1;
    vin = v;
    @(negedge clk);
    cs_n = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (done) begin lat = i; break; end
    end
    chk("R4 latency", lat, CONV + 1);
    chk("R5 final code", result, v);
    chk("R6 done pulse", done, 1);
    cs_n = 1;
    @(negedge clk);
    chk("R6 done clears", done, 0);
  endtask

  logic [W-1:0] r0;

  initial begin
    cs_n = 1; shdn_n = 1; vin = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; run_cmp = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 hold", hold, 0);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);
    chk("R1 dac_code", dac_code, 0);

    // start before wake-up after reset is refused
    cs_n = 0;
    @(negedge clk);
    chk("R9 start before wake", busy, 0);
    cs_n = 1;
    repeat (WAKE + 2) @(negedge clk);

    convert(12'h000);
    convert(12'hFFF);
    convert(12'hA5A);
    convert(12'h800);
    convert(12'h7FF);
    convert(12'h001);
    convert(12'h555);

    // level low after completion does not restart
    vin = 12'h3C3;
    @(negedge clk); cs_n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (done) break; end
    chk("R5 level run result", result, 12'h3C3);
    repeat (20) @(negedge clk);
    chk("R2 no restart on low level", busy, 0);
    cs_n = 1;
    @(negedge clk);

    // abort mid-conversion, then acquisition window
    r0 = result; vin = 12'h123;
    @(negedge clk); cs_n = 0;
    repeat (8) @(negedge clk);
    chk("R3 busy mid conversion", busy, 1);
    cs_n = 1;
    @(negedge clk);
    chk("R7 aborted busy", busy, 0);
    chk("R7 result kept", result, r0);
    cs_n = 0;
    repeat (3) @(negedge clk);
    chk("R7 start ignored in window", busy, 0);
    cs_n = 1;
    repeat (ACQ + 2) @(negedge clk);
    convert(12'h123);

    // abort exactly at the completing edge
    r0 = result; vin = 12'h6B9;
    @(negedge clk); cs_n = 0;
    repeat (CONV) @(negedge clk);
    chk("R8 busy at last trial", busy, 1);
    cs_n = 1;
    @(negedge clk);
    chk("R8 no done", done, 0);
    chk("R8 result kept", result, r0);
    chk("R8 idle", busy, 0);
    cs_n = 0;
    @(negedge clk);
    chk("R8 window follows", busy, 0);
    cs_n = 1;
    repeat (ACQ + 2) @(negedge clk);

    // abort one edge later: normal completion
    cs_n = 0;
    repeat (CONV + 1) @(negedge clk);
    chk("R8 later raise completes", done, 1);
    chk("R8 later raise result", result, 12'h6B9);
    cs_n = 1;
    @(negedge clk);

    // shutdown mid-conversion and wake-up interval
    r0 = result; vin = 12'h2F0;
    @(negedge clk); cs_n = 0;
    repeat (10) @(negedge clk);
    shdn_n = 0;
    @(negedge clk);
    chk("R9 shutdown stops", busy, 0);
    chk("R9 no done", done, 0);
    chk("R9 result kept", result, r0);
    cs_n = 1;
    @(negedge clk);
    cs_n = 0;
    @(negedge clk);
    chk("R9 start in shutdown", busy, 0);
    cs_n = 1; shdn_n = 1;
    repeat (5) @(negedge clk);
    cs_n = 0;
    @(negedge clk);
    chk("R9 start during wake-up", busy, 0);
    cs_n = 1;
    repeat (WAKE) @(negedge clk);
    convert(12'h2F0);

    repeat (3) @(negedge clk);
    run_cmp = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule